// File: doc/BRIEF.md
# Audio Codec Rate-Change Sequencer

This block reprograms the clocking of an external audio codec whenever a new sample rate is requested. A 3-bit rate code and a one-cycle change strobe come in. The block maps the code to three settings: which of two master oscillators feeds the codec, the level of the codec's divider-select pin, and the codec speed mode. It never alters these settings while the codec is running. It first pulls the codec's active-low reset down, then applies the new settings, and then holds reset for one millisecond so the clocks can settle. After that it releases reset and pulses `done`.

A strobe that arrives during a sequence is stored, and only the latest such strobe is kept. It runs once the current sequence ends. A code outside the six supported rates is refused with a one-cycle error pulse, and the running configuration stays as it is. After system reset the block starts with the codec held in reset and runs a complete sequence for 48 kHz without any request.

The hold time is counted on the block's own clock. It is set by the parameters `CLK_HZ` (clock frequency) and `HOLD_HZ` (reciprocal of the hold time, 1000 for 1 ms).

Top module: `codec_rate_seq`

## Requirements
- R1: While and after system reset, `codec_rst_n` is low and `busy` is high. With no request, the block then completes one sequence that ends with `mclk_sel`=1, `div_sel`=1 and `speed_mode`=0 (48 kHz).
- R2: Any change of `mclk_sel`, `div_sel` or `speed_mode` happens only when `codec_rst_n` was already low in the previous cycle and is still low.
- R3: After the new settings are applied, `codec_rst_n` stays low for exactly HOLD_CYC = CLK_HZ/HOLD_HZ further cycles. That makes HOLD_CYC+1 low cycles in total from the first low cycle to the release.
- R4: Rate codes are 0=44.1, 1=48, 2=88.2, 3=96, 4=176.4 and 5=192 kHz. Bit 0 of the code selects the oscillator: 0 gives the 11.2896 MHz source with `mclk_sel`=`div_sel`=0, and 1 gives the 24.576 MHz source with both at 1. `mclk_sel` always equals `div_sel`.
- R5: `speed_mode` is code bits [2:1]: 0 = single-speed (44.1/48), 1 = double-speed (88.2/96), 2 = quad-speed (176.4/192).
- R6: Codes 6 and 7 produce a one-cycle `rate_err` pulse and start no sequence. `busy` stays low, `codec_rst_n` stays high and the settings are unchanged.
- R7: A strobe that arrives while `busy` is high is stored. Only the latest one is kept, and it is acted on after the current sequence ends. If the stored code is invalid, it is refused as in R6.
- R8: `busy` is high from the cycle in which `codec_rst_n` first goes low through the last low cycle. In every cycle after reset, `busy` equals the inverse of `codec_rst_n`.
- R9: `done` is a single-cycle pulse, issued in the first cycle in which `codec_rst_n` is high again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running block clock |
| rst_n | input | 1 | Active-low system reset |
| rate_code | input | 3 | Requested sample-rate code |
| rate_req | input | 1 | One-cycle rate change strobe |
| codec_rst_n | output | 1 | Active-low codec reset |
| mclk_sel | output | 1 | Master oscillator select (1 = 24.576 MHz) |
| div_sel | output | 1 | Codec divider-select pin |
| speed_mode | output | 2 | Codec speed mode |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle pulse on codec reset release |
| rate_err | output | 1 | One-cycle pulse on a refused code |

## Verification
The bench builds the block with `CLK_HZ`=20000 and `HOLD_HZ`=1000, which gives a 20-cycle hold. At that length every one of the six rates, repeated requests, strobes stored during a hold and invalid codes can all be run end to end in a few hundred cycles. The exact count of low reset cycles is measured on each release, so an off-by-one in the hold counter shows up directly rather than being hidden inside a millisecond-long wait.

// File: rtl/codec_rate_seq.sv
module codec_rate_seq #(
  parameter int CLK_HZ  = 250_000_000,
  parameter int HOLD_HZ = 1000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [2:0] rate_code,
  input  logic       rate_req,
  output logic       codec_rst_n,
  output logic       mclk_sel,
  output logic       div_sel,
  output logic [1:0] speed_mode,
  output logic       busy,
  output logic       done,
  output logic       rate_err
);

  localparam int HOLD_CYC = (CLK_HZ / HOLD_HZ < 1) ? 1 : CLK_HZ / HOLD_HZ;
  localparam int CW       = $clog2(HOLD_CYC + 1);
  localparam int NCODES   = 6;

  typedef enum logic [1:0] {S_IDLE, S_SWITCH, S_HOLD} st_t;

  st_t           st;
  logic [2:0]    tgt, pend_code;
  logic          pend_q, rst_q, fam_q, done_q, err_q;
  logic [1:0]    spd_q;
  logic [CW-1:0] cnt;

  wire       have      = rate_req | pend_q;
  wire [2:0] take_code = rate_req ? rate_code : pend_code;
  wire       code_ok   = int'(take_code) < NCODES;
  wire       hold_end  = cnt == CW'(HOLD_CYC - 1);

  assign codec_rst_n = rst_q;
  assign mclk_sel    = fam_q;
  assign div_sel     = fam_q;
  assign speed_mode  = spd_q;
  assign busy        = st != S_IDLE;
  assign done        = done_q;
  assign rate_err    = err_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= S_SWITCH;
      tgt       <= 3'd1;
      rst_q     <= 1'b0;
      fam_q     <= 1'b1;
      spd_q     <= 2'd0;
      cnt       <= '0;
      pend_q    <= 1'b0;
      pend_code <= 3'd0;
      done_q    <= 1'b0;
      err_q     <= 1'b0;
    end else begin
      done_q <= 1'b0;
      err_q  <= 1'b0;
      if (st != S_IDLE && rate_req) begin
        pend_q    <= 1'b1;
        pend_code <= rate_code;
      end
      unique case (st)
        S_IDLE: begin
          pend_q <= 1'b0;
          if (have) begin
            if (code_ok) begin
              tgt   <= take_code;
              rst_q <= 1'b0;
              st    <= S_SWITCH;
            end else begin
              err_q <= 1'b1;
            end
          end
        end
        S_SWITCH: begin
          fam_q <= tgt[0];
          spd_q <= tgt[2:1];
          cnt   <= '0;
          st    <= S_HOLD;
        end
        S_HOLD: begin
          if (hold_end) begin
            rst_q  <= 1'b1;
            done_q <= 1'b1;
            st     <= S_IDLE;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  logic [CW:0] low_run;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      low_run <= '0;
    else if (rst_q)  low_run <= '0;
    else             low_run <= low_run + 1'b1;
  end

  a_r2_reset_before_switch: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable({fam_q, spd_q}) |-> (!rst_q && !$past(rst_q)));

  a_r3_hold_length: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_q) |-> (int'(low_run) == HOLD_CYC + 1));

  a_r9_done_on_release: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_q) |-> done_q);

  a_r9_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |=> !done_q);

  a_r8_idle_at_done: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |-> !busy);

  a_r6_err_no_sequence: assert property (@(posedge clk) disable iff (!rst_n)
    err_q |-> (!busy && rst_q));

endmodule

// File: tb/codec_rate_seq_test.sv
module codec_rate_seq_test;
  localparam int CLK_HZ  = 20000;
  localparam int HOLD_HZ = 1000;
  localparam int HOLD    = CLK_HZ / HOLD_HZ;

  logic clk = 1'b0;
  logic rst_n;
  logic [2:0] rate_code;
  logic rate_req;
  logic codec_rst_n, mclk_sel, div_sel, busy, done, rate_err;
  logic [1:0] speed_mode;

  int checks = 0;
  int failures = 0;
  int err_seen = 0;
  int err_exp = 0;
  bit finished = 0;
  logic [3:0] exp_q[$];

  always #2 clk = ~clk;

  codec_rate_seq #(.CLK_HZ(CLK_HZ), .HOLD_HZ(HOLD_HZ)) uut (
    .clk(clk), .rst_n(rst_n), .rate_code(rate_code), .rate_req(rate_req),
    .codec_rst_n(codec_rst_n), .mclk_sel(mclk_sel), .div_sel(div_sel),
    .speed_mode(speed_mode), .busy(busy), .done(done), .rate_err(rate_err));

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic strobe(input logic [2:0] code);
    rate_code = code;
    rate_req  = 1'b1;
    @(negedge clk);
    rate_req  = 1'b0;
  endtask

  task automatic request(input logic [2:0] code);
    exp_q.push_back({1'b0, code});
    strobe(code);
  endtask

  task automatic wait_idle();
    int quiet = 0;
    while (quiet < 3) begin
      @(negedge clk);
      if (!busy && !done) quiet++;
      else quiet = 0;
    end
  endtask

  // scoreboard monitor
  logic [2:0] prev_cfg;
  logic prev_rst, prev_done;
  int lowcnt;
  always @(negedge clk) begin
    if (!rst_n) begin
      chk(codec_rst_n == 1'b0, "R1 codec reset low in reset", codec_rst_n, 0);
      chk(busy == 1'b1, "R1 busy in reset", busy, 1);
      prev_cfg  = {div_sel, speed_mode};
      prev_rst  = 1'b0;
      prev_done = 1'b0;
      lowcnt    = -1000;
    end else begin
      chk(busy == !codec_rst_n, "R8 busy vs codec reset", busy, !codec_rst_n);
      chk(mclk_sel == div_sel, "R4 mclk_sel equals div_sel", mclk_sel, div_sel);
      if ({div_sel, speed_mode} != prev_cfg)
        chk(!codec_rst_n && !prev_rst, "R2 switch under reset", {codec_rst_n, prev_rst}, 0);
      if (prev_done) chk(!done, "R9 done one cycle", done, 0);
      if (rate_err) err_seen++;
      if (done) begin
        logic [3:0] e;
        chk(codec_rst_n && !prev_rst, "R9 done at release", {prev_rst, codec_rst_n}, 1);
        chk(exp_q.size() > 0, "R7 unexpected sequence", 0, 1);
        if (exp_q.size() > 0) begin
          e = exp_q.pop_front();
          chk(mclk_sel == e[0], e[3] ? "R1 boot mclk_sel" : "R4 mclk_sel", mclk_sel, e[0]);
          chk(div_sel == e[0], "R4 div_sel", div_sel, e[0]);
          chk(speed_mode == e[2:1], e[3] ? "R1 boot speed" : "R5 speed_mode", speed_mode, e[2:1]);
          if (!e[3]) chk(lowcnt == HOLD + 1, "R3 hold cycles", lowcnt, HOLD + 1);
        end
      end
      if (!codec_rst_n) lowcnt++;
      else lowcnt = 0;
      prev_cfg  = {div_sel, speed_mode};
      prev_rst  = codec_rst_n;
      prev_done = done;
    end
  end

  task automatic bad_code(input logic [2:0] code);
    logic [2:0] cfg;
    cfg = {div_sel, speed_mode};
    err_exp++;
    strobe(code);
    chk(rate_err == 1'b1, "R6 err pulse", rate_err, 1);
    chk(busy == 1'b0, "R6 no sequence", busy, 0);
    @(negedge clk);
    chk(rate_err == 1'b0, "R6 err single cycle", rate_err, 0);
    chk(codec_rst_n == 1'b1, "R6 codec reset kept high", codec_rst_n, 1);
    chk({div_sel, speed_mode} == cfg, "R6 config kept", {div_sel, speed_mode}, cfg);
  endtask

  initial begin
    rst_n = 1'b0;
    rate_req = 1'b0;
    rate_code = 3'd0;
    exp_q.push_back(4'b1_001);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    wait_idle();
    for (int c = 0; c < 6; c++) begin
      request(3'(c));
      wait_idle();
    end
    request(3'd5);
    wait_idle();
    bad_code(3'd6);
    bad_code(3'd7);
    wait_idle();
    // R7: stored strobes, latest wins
    request(3'd2);
    repeat (5) @(negedge clk);
    strobe(3'd4);
    repeat (2) @(negedge clk);
    request(3'd3);
    wait_idle();
    // R7: stored invalid code is refused after the sequence
    request(3'd0);
    repeat (4) @(negedge clk);
    err_exp++;
    strobe(3'd7);
    wait_idle();
    chk(codec_rst_n == 1'b1 && speed_mode == 2'd0 && div_sel == 1'b0,
        "R7 stored invalid kept config", {codec_rst_n, div_sel, speed_mode}, 3'b100);
    chk(err_seen == err_exp, "R6 error pulse count", err_seen, err_exp);
    chk(exp_q.size() == 0, "R7 all sequences seen", exp_q.size(), 0);
    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      checks++;
      failures++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule